// File: doc/BRIEF.md
# Smart Card Initial Character Analyzer

This block watches the contact lines of a smart card interface and judges the first byte the card sends after its reset is released. It brings the card clock, card reset and supply lines into the system clock domain, counts rising edges of the card clock from the moment reset goes high, and takes the first byte handed over by an external byte receiver as the initial character.

From that byte's value it decides the coding convention. It then presents the bit order and line polarity that the receiver and the downstream protocol monitor should use. It also flags a byte that matches neither legal pattern, a card that answers too soon, and a card that has not answered by the deadline. Downstream logic gates its own work on the activation and error flags.

All session results stay latched until the card reset is asserted again or the supply is removed. An active-low asynchronous system reset clears everything.

Top module: `scInitCharMon`

## Requirements
- R1: While `rstN` is low, every output is 0.
- R2: `active` goes to 1 once the supply line is high and a rising card clock edge has been seen. It returns to 0 after the supply line falls.
- R3: The first byte strobed on `rxValid` while the card reset line is high and supply is present sets `tsSeen`. The value 0x3B, as seen by a least-significant-bit-first, non-inverting receiver, selects direct convention: `invConv`, `msbFirst` and `dataInvert` are all 0, and `tsBad` is 0.
- R4: The first byte 0x03 selects indirect convention: `invConv`, `msbFirst` and `dataInvert` are all 1, and `tsBad` is 0.
- R5: A first byte other than 0x3B or 0x03 sets `tsBad` and leaves the convention direct (`invConv` = 0).
- R6: Bytes strobed after the first byte of a session, and bytes strobed while the card reset line is low, change no output.
- R7: The arrival count is the number of card clock rising edges seen since reset release. `tsEarly` is set when the first byte arrives with a count below EARLY_CYCLES (default 400), and stays 0 at a count of EARLY_CYCLES or more.
- R8: `tsLate` is set when the count reaches LATE_CYCLES (default 40000) with no byte received yet. It is not set one edge earlier, and it stays set when a byte arrives afterwards.
- R9: Asserting the card reset line (low) or removing supply clears `tsSeen`, `tsBad`, `tsEarly`, `tsLate` and the convention, and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| cardClk | input | 1 | Card clock line (asynchronous) |
| cardRstN | input | 1 | Card reset line, low holds the card in reset (asynchronous) |
| cardVdd | input | 1 | Card supply present (asynchronous) |
| rxValid | input | 1 | One-cycle strobe: a byte was received |
| rxByte | input | 8 | Received byte, as taken LSB first without inversion |
| active | output | 1 | Card powered and clocked |
| tsSeen | output | 1 | Initial character received this session |
| tsBad | output | 1 | Initial character was not a legal pattern |
| tsEarly | output | 1 | Initial character came before the early window closed |
| tsLate | output | 1 | Deadline passed with no initial character |
| invConv | output | 1 | Indirect convention detected |
| msbFirst | output | 1 | Receiver must take data most significant bit first |
| dataInvert | output | 1 | Receiver must invert data bits |

## Verification
The bench places the first byte at exactly 399 and 400 card clock edges to pin the early boundary. A comparison off by one, or one taken against the wrong edge count, flips `tsEarly` at one of the two points. It drives the count to one short of the deadline and then to the deadline itself, then sends a byte, so a design that sets the late flag early, or clears it when the byte arrives, is caught. Second bytes and bytes sent while the card is held in reset are injected to expose a design that keeps re-deciding the convention. Card reset and supply removal are applied mid-session to show that stale flags are cleared.

// File: rtl/scTsPkg.sv
package scTsPkg;

  // Initial-character codes as delivered by an LSB-first, non-inverting receiver
  localparam logic [7:0] TS_DIRECT  = 8'h3B;
  localparam logic [7:0] TS_INVERSE = 8'h03;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
  } tsStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic vddOk;
    logic rstReleased;
    logic clkRise;
    logic beforeEarly;
    logic reachedLate;
    logic codeDirect;
    logic codeInverse;
  } tsStat_t;

endpackage

// File: rtl/scTsSync.sv
module scTsSync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/scTsDatapath.sv
module scTsDatapath
  import scTsPkg::*;
#(
  parameter int EARLY_CYCLES = 400,
  parameter int LATE_CYCLES  = 40000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cardClk,
  input  logic      cardRstN,
  input  logic      cardVdd,
  input  logic [7:0] rxByte,
  input  tsStrobe_t strobe,
  output tsStat_t   stat
);

  localparam int CW = $clog2(LATE_CYCLES + 1);
  localparam logic [CW-1:0] EARLY_LIM = CW'(EARLY_CYCLES);
  localparam logic [CW-1:0] LATE_LIM  = CW'(LATE_CYCLES);

  logic [2:0]    lineSync;
  logic          clkPrev;
  logic [CW-1:0] edgeCnt;

  scTsSync #(.WIDTH(3), .STAGES(SYNC_STAGES)) lineSync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({cardVdd, cardRstN, cardClk}),
    .dout(lineSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= lineSync[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  edgeCnt <= '0;
    else if (strobe.cntClear)                   edgeCnt <= '0;
    else if (strobe.cntStep && edgeCnt < LATE_LIM) edgeCnt <= edgeCnt + 1'b1;
  end

  always_comb begin
    stat.vddOk       = lineSync[2];
    stat.rstReleased = lineSync[1];
    stat.clkRise     = lineSync[0] & ~clkPrev;
    stat.beforeEarly = edgeCnt < EARLY_LIM;
    stat.reachedLate = edgeCnt >= LATE_LIM;
    stat.codeDirect  = rxByte == TS_DIRECT;
    stat.codeInverse = rxByte == TS_INVERSE;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= LATE_LIM); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> edgeCnt == '0); // R9

endmodule

// File: rtl/scTsControl.sv
module scTsControl
  import scTsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  tsStat_t   stat,
  output tsStrobe_t strobe,
  output logic      active,
  output logic      tsSeen,
  output logic      tsBad,
  output logic      tsEarly,
  output logic      tsLate,
  output logic      invConv
);

  logic sessionOn;

  assign sessionOn = stat.vddOk & stat.rstReleased;

  always_comb begin
    strobe.cntClear = ~sessionOn;
    strobe.cntStep  = sessionOn & stat.clkRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             active <= 1'b0;
    else if (!stat.vddOk)  active <= 1'b0;
    else if (stat.clkRise) active <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsSeen  <= 1'b0;
      tsBad   <= 1'b0;
      tsEarly <= 1'b0;
      tsLate  <= 1'b0;
      invConv <= 1'b0;
    end else if (!sessionOn) begin
      tsSeen  <= 1'b0;
      tsBad   <= 1'b0;
      tsEarly <= 1'b0;
      tsLate  <= 1'b0;
      invConv <= 1'b0;
    end else begin
      if (rxValid && !tsSeen) begin
        tsSeen  <= 1'b1;
        invConv <= stat.codeInverse;
        tsBad   <= ~(stat.codeDirect | stat.codeInverse);
        tsEarly <= stat.beforeEarly;
      end
      if (stat.reachedLate && !tsSeen) tsLate <= 1'b1;
    end
  end

  AST_ACTIVE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !stat.vddOk |=> !active); // R2
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    tsSeen && sessionOn |=> tsSeen); // R6
  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    tsSeen && sessionOn |=> $stable(invConv)); // R6
  AST_BAD_NEEDS_TS: assert property (@(posedge clk) disable iff (!rstN)
    tsBad |-> tsSeen); // R5
  AST_BAD_IS_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !(tsBad && invConv)); // R4
  AST_EARLY_NEEDS_TS: assert property (@(posedge clk) disable iff (!rstN)
    tsEarly |-> tsSeen); // R7
  AST_LATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    tsLate && sessionOn |=> tsLate); // R8
  AST_SESSION_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !sessionOn |=> !tsSeen && !tsLate && !tsEarly && !invConv); // R9

endmodule

// File: rtl/scInitCharMon.sv
module scInitCharMon
  import scTsPkg::*;
#(
  parameter int EARLY_CYCLES = 400,
  parameter int LATE_CYCLES  = 40000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cardClk,
  input  logic       cardRstN,
  input  logic       cardVdd,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic       active,
  output logic       tsSeen,
  output logic       tsBad,
  output logic       tsEarly,
  output logic       tsLate,
  output logic       invConv,
  output logic       msbFirst,
  output logic       dataInvert
);

  tsStrobe_t strobe;
  tsStat_t   stat;

  scTsDatapath #(
    .EARLY_CYCLES(EARLY_CYCLES),
    .LATE_CYCLES (LATE_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .cardClk (cardClk),
    .cardRstN(cardRstN),
    .cardVdd (cardVdd),
    .rxByte  (rxByte),
    .strobe  (strobe),
    .stat    (stat)
  );

  scTsControl control_i (
    .clk    (clk),
    .rstN   (rstN),
    .rxValid(rxValid),
    .stat   (stat),
    .strobe (strobe),
    .active (active),
    .tsSeen (tsSeen),
    .tsBad  (tsBad),
    .tsEarly(tsEarly),
    .tsLate (tsLate),
    .invConv(invConv)
  );

  // Indirect convention: MSB first and inverted levels
  assign msbFirst   = invConv;
  assign dataInvert = invConv;

endmodule

// File: tb/scInitCharMon_tb.sv
module scInitCharMon_tb_top;

  localparam int LATE_TB = 1000;
  localparam int NVEC    = 7;

  // Vector table: first byte, card clock edges before it, expected {bad, inv, early}
  localparam logic [7:0] VEC_BYTE [NVEC] = '{8'h3B, 8'h03, 8'h3F, 8'h3B, 8'h3B, 8'h03, 8'h00};
  localparam int         VEC_EDGE [NVEC] = '{500,   500,   500,   399,   400,   10,    600};
  localparam logic [2:0] VEC_EXP  [NVEC] = '{3'b000, 3'b010, 3'b100, 3'b001, 3'b000, 3'b011, 3'b100};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cardClk = 1'b0;
  logic cardRstN = 1'b0;
  logic cardVdd = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic active, tsSeen, tsBad, tsEarly, tsLate, invConv, msbFirst, dataInvert;

  int nRun = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  scInitCharMon #(.LATE_CYCLES(LATE_TB)) dut_i (
    .clk(clk), .rstN(rstN), .cardClk(cardClk), .cardRstN(cardRstN), .cardVdd(cardVdd),
    .rxValid(rxValid), .rxByte(rxByte), .active(active), .tsSeen(tsSeen), .tsBad(tsBad),
    .tsEarly(tsEarly), .tsLate(tsLate), .invConv(invConv), .msbFirst(msbFirst),
    .dataInvert(dataInvert)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      cardClk = 1'b1; waitClk(2);
      cardClk = 1'b0; waitClk(2);
    end
    waitClk(6);
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxByte = b; rxValid = 1'b1; waitClk(1);
    rxValid = 1'b0; waitClk(3);
  endtask

  task automatic newSession;
    cardVdd = 1'b1; cardRstN = 1'b0; waitClk(6);
    cardRstN = 1'b1; waitClk(6);
  endtask

  // {active, tsSeen, tsBad, tsEarly, tsLate, invConv, msbFirst, dataInvert}
  function automatic logic [7:0] outs();
    return {active, tsSeen, tsBad, tsEarly, tsLate, invConv, msbFirst, dataInvert};
  endfunction

  initial begin
    waitClk(3);
    chk("R1 reset state", outs(), 8'h00);
    rstN = 1'b1;
    waitClk(2);

    // R2: powered but no clock yet
    newSession();
    chk("R2 no clock no activation", {7'd0, active}, 8'd1 & 8'd0);
    edges(3);
    chk("R2 activation after clock", {7'd0, active}, 8'd1);

    // Vector table: R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      newSession();
      edges(VEC_EDGE[v]);
      sendByte(VEC_BYTE[v]);
      chk("R3 tsSeen", {7'd0, tsSeen}, 8'd1);
      chk("R5 tsBad", {7'd0, tsBad}, {7'd0, VEC_EXP[v][2]});
      chk("R4 convention", {5'd0, invConv, msbFirst, dataInvert}, {5'd0, {3{VEC_EXP[v][1]}}});
      chk("R7 early flag", {7'd0, tsEarly}, {7'd0, VEC_EXP[v][0]});
      chk("R8 no late", {7'd0, tsLate}, 8'd0);
    end

    // R6: second byte ignored
    newSession();
    edges(500);
    sendByte(8'h3B);
    sendByte(8'h03);
    chk("R6 second byte ignored", {6'd0, invConv, tsBad}, 8'd0);
    // R6: byte while card held in reset ignored
    cardRstN = 1'b0; waitClk(6);
    sendByte(8'h03);
    cardRstN = 1'b1; waitClk(6);
    edges(20);
    chk("R6 byte during card reset ignored", {6'd0, tsSeen, invConv}, 8'd0);

    // R8: deadline
    newSession();
    edges(LATE_TB - 1);
    chk("R8 not late one edge short", {7'd0, tsLate}, 8'd0);
    edges(1);
    chk("R8 late at deadline", {7'd0, tsLate}, 8'd1);
    sendByte(8'h3B);
    chk("R8 late held after byte", {6'd0, tsLate, tsSeen}, 8'd3);
    chk("R7 late byte not early", {7'd0, tsEarly}, 8'd0);

    // R9: card reset clears session, supply keeps activation
    cardRstN = 1'b0; waitClk(6);
    chk("R9 card reset clears", {5'd0, tsSeen, tsLate, active}, 8'd1);
    cardRstN = 1'b1; waitClk(6);
    edges(50);
    sendByte(8'h03);
    chk("R4 indirect second session", {7'd0, invConv}, 8'd1);
    cardVdd = 1'b0; waitClk(6);
    chk("R9 supply drop clears", outs(), 8'h00);
    chk("R2 supply drop deactivates", {7'd0, active}, 8'd0);

    // R1: system reset mid-session
    newSession();
    edges(30);
    sendByte(8'h03);
    rstN = 1'b0; waitClk(2);
    chk("R1 reset mid-session", outs(), 8'h00);
    rstN = 1'b1; waitClk(2);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule